// File: doc/BRIEF.md
# ECC Error Capture Register Bank

This block sits beside the ECC datapath of a DRAM controller and keeps a record of memory errors for software. The datapath raises a one-cycle pulse for each correctable (single-bit) or uncorrectable (multi-bit) error it sees. With each pulse it also supplies the physical address that failed, the 8-bit ECC syndrome and which of two channels was involved. The block sets a sticky flag for each kind of error. It also keeps one captured record: the failing 4 KiB block, the syndrome and the channel.

Software reaches the block through a simple register port. Writes take one cycle and reads are combinational. Software polls or takes an interrupt, reads the captured record, and then clears the flags by writing ones to them. The captured record follows a severity rule. An uncorrectable error may replace the record of an earlier correctable error. A later correctable error never replaces the record of an uncorrectable one. A command register holds one signalling enable per error kind, and these drive a registered interrupt output.

Top module: `ecc_err_capture`

## Requirements
- R1: After reset every register (offsets 0 to 4) reads zero and `err_irq` is low.
- R2: The status word at offset 0 is 16 bits. A correctable event sets bit 0 and an uncorrectable event sets bit 7. All other status bits read zero.
- R3: Writing to offset 0 clears each of bits 0 and 7 that is 1 in the written data, and leaves bits written 0 unchanged. If an event and a clear hit the same bit in the same cycle, the bit ends up set.
- R4: Offset 2 reads the captured failing address with bits 31:12 kept and bits 11:0 zero.
- R5: Offset 3 reads the captured syndrome in bits 7:0. Offset 4 reads the captured channel in bit 0, with every other bit zero.
- R6: When both status bits are clear, a correctable event captures its address, syndrome and channel. While either status bit is set, a correctable event leaves the captured record unchanged.
- R7: An uncorrectable event that arrives while only the correctable bit is set replaces the captured record with its own data, and both status bits then read set.
- R8: While the uncorrectable bit is set, neither a correctable event nor a further uncorrectable event changes the captured record.
- R9: If correctable and uncorrectable events arrive in the same cycle, both status bits are set and the uncorrectable event's data is captured.
- R10: Once both status bits are clear, the next event of either kind is captured afresh. A clear written in the same cycle as an event counts as already done for the capture decision, so that event's data is captured.
- R11: Offset 1 is the command register. Bit 7 enables signalling for correctable errors and bit 8 for uncorrectable errors. All other bits read zero.
- R12: `err_irq` is high one cycle after a cycle in which (status bit 0 AND command bit 7) OR (status bit 7 AND command bit 8) holds, and low otherwise.
- R13: Writes to offsets 2, 3, 4 and to the unmapped offsets 5 to 7 have no effect. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_evt | input | 1 | Correctable-error pulse from the datapath |
| ue_evt | input | 1 | Uncorrectable-error pulse from the datapath |
| evt_addr | input | ADDR_W | Physical address of the failing access |
| evt_syn | input | SYN_W | ECC syndrome of the failing access |
| evt_chan | input | 1 | Channel of the failing access |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr` |
| err_irq | output | 1 | Registered error-signalling output |

## Verification
The bench targets the severity ordering of the captured record. A correctable error that follows an uncorrectable one, or a second uncorrectable error, must leave the record alone. A design with a plain "capture on any event" rule would report the newer address instead. It also drives a clear and an event into the same cycle. A design that let the clear win would drop the error. A design that decided capture on the flags before the clear would keep the stale record. Simultaneous correctable and uncorrectable pulses check that the uncorrectable data wins. The interrupt is sampled one cycle after each flag or enable change to expose a missing or extra register stage.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
  // status word layout; bit positions are decoded by software
  localparam int STS_W      = 16;
  localparam int CE_STS_BIT = 0;
  localparam int UE_STS_BIT = 7;
  // command word enable positions
  localparam int CE_EN_BIT  = 7;
  localparam int UE_EN_BIT  = 8;
  // error sources, index into per-source vectors
  localparam int N_SRC  = 2;
  localparam int SRC_CE = 0;
  localparam int SRC_UE = 1;
  // register offsets
  localparam int RA_W = 3;
  typedef enum logic [RA_W-1:0] {
    OFS_STATUS = 3'd0,
    OFS_CMD    = 3'd1,
    OFS_ADDR   = 3'd2,
    OFS_SYN    = 3'd3,
    OFS_CHAN   = 3'd4
  } reg_ofs_e;

  // next value of a sticky write-one-to-clear bit: a set beats a clear
  function automatic logic w1c_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  // flag value that remains once this cycle's clear is applied
  function automatic logic survives(input logic cur, input logic clr);
    return cur & ~clr;
  endfunction

  function automatic int sts_pos(input int src);
    return (src == SRC_CE) ? CE_STS_BIT : UE_STS_BIT;
  endfunction

  function automatic int en_pos(input int src);
    return (src == SRC_CE) ? CE_EN_BIT : UE_EN_BIT;
  endfunction
endpackage

// File: rtl/ecc_flag_bank.sv
module ecc_flag_bank import ecc_cap_pkg::*; #(
  parameter int NF = N_SRC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_i,
  input  logic [NF-1:0] clr_i,
  output logic [NF-1:0] flag_o,
  output logic [NF-1:0] held_o
);
  logic [NF-1:0] flag_q;

  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= w1c_next(flag_q[i], set_i[i], clr_i[i]);
    end

    assign held_o[i] = survives(flag_q[i], clr_i[i]);

    // R3: an event in the same cycle as a clear leaves the bit set
    assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> flag_o[i]);
    // R3: a clear without an event empties a set bit
    assert_clear_works_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !flag_o[i]);
    // R3: with no event and no clear the bit does not move
    assert_flag_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i[i] && !set_i[i]) |=> $stable(flag_o[i]));
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/ecc_capture.sv
module ecc_capture #(
  parameter int ADDR_W    = 32,
  parameter int BLK_SHIFT = 12,
  parameter int SYN_W     = 8,
  localparam int BLK_W    = ADDR_W - BLK_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_evt,
  input  logic              ue_evt,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic [SYN_W-1:0]  evt_syn,
  input  logic              evt_chan,
  input  logic              ce_held,
  input  logic              ue_held,
  output logic [BLK_W-1:0]  cap_blk,
  output logic [SYN_W-1:0]  cap_syn,
  output logic              cap_chan,
  output logic              take_ue,
  output logic              take_ce
);
  function automatic logic [BLK_W-1:0] block_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:BLK_SHIFT];
  endfunction

  logic unused_addr_lo;
  assign unused_addr_lo = ^evt_addr[BLK_SHIFT-1:0];

  // an uncorrectable event wins unless an uncorrectable record is still held
  assign take_ue = ue_evt & ~ue_held;
  // a correctable event is recorded only into an empty bank
  assign take_ce = ce_evt & ~ue_evt & ~ce_held & ~ue_held;

  logic load;
  assign load = take_ue | take_ce;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_blk  <= '0;
      cap_syn  <= '0;
      cap_chan <= 1'b0;
    end else if (load) begin
      cap_blk  <= block_of(evt_addr);
      cap_syn  <= evt_syn;
      cap_chan <= evt_chan;
    end
  end

  // R6: a correctable event into an occupied bank keeps the record
  assert_ce_no_overwrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_evt && !ue_evt && (ce_held || ue_held))
      |=> ($stable(cap_blk) && $stable(cap_syn) && $stable(cap_chan)));
  // R8: a held uncorrectable record is frozen
  assert_ue_record_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ue_held |=> ($stable(cap_blk) && $stable(cap_syn) && $stable(cap_chan)));
  // R7 / R9: an accepted uncorrectable event lands in the record
  assert_ue_captured_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_evt && !ue_held)
      |=> (cap_blk == $past(evt_addr[ADDR_W-1:BLK_SHIFT]) && cap_syn == $past(evt_syn)
           && cap_chan == $past(evt_chan)));
endmodule

// File: rtl/ecc_cmd_irq.sv
module ecc_cmd_irq import ecc_cap_pkg::*; #(
  parameter int NF = N_SRC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [NF-1:0] wen_i,
  input  logic [NF-1:0] flag_i,
  output logic [NF-1:0] en_o,
  output logic          irq_o
);
  logic [NF-1:0] en_q;
  logic          irq_q;
  logic          raise;

  function automatic logic any_enabled(input logic [NF-1:0] f, input logic [NF-1:0] e);
    return |(f & e);
  endfunction

  assign raise = any_enabled(flag_i, en_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      if (wr_i) en_q <= wen_i;
      irq_q <= raise;
    end
  end

  assign en_o  = en_q;
  assign irq_o = irq_q;

  // R11: a command write loads the enables
  assert_cmd_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> en_o == $past(wen_i));
  // R12: no flag set means no signal on the next cycle
  assert_irq_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_i == '0) |=> !irq_o);
  // R12: the signal only rises after an enabled flag
  assert_irq_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(|(flag_i & en_o)));
endmodule

// File: rtl/ecc_reg_port.sv
module ecc_reg_port import ecc_cap_pkg::*; #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int BLK_SHIFT = 12,
  parameter int SYN_W     = 8,
  localparam int BLK_W    = ADDR_W - BLK_SHIFT
) (
  input  logic              reg_wr,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [N_SRC-1:0]  flag,
  input  logic [N_SRC-1:0]  en,
  input  logic [BLK_W-1:0]  cap_blk,
  input  logic [SYN_W-1:0]  cap_syn,
  input  logic              cap_chan,
  output logic [N_SRC-1:0]  sts_clr,
  output logic              cmd_wr,
  output logic [N_SRC-1:0]  cmd_wen,
  output logic [DATA_W-1:0] reg_rdata
);
  function automatic logic [STS_W-1:0] status_word(input logic [N_SRC-1:0] f);
    logic [STS_W-1:0] w;
    w = '0;
    for (int i = 0; i < N_SRC; i++) w[sts_pos(i)] = f[i];
    return w;
  endfunction

  function automatic logic [STS_W-1:0] cmd_word(input logic [N_SRC-1:0] e);
    logic [STS_W-1:0] w;
    w = '0;
    for (int i = 0; i < N_SRC; i++) w[en_pos(i)] = e[i];
    return w;
  endfunction

  function automatic logic [ADDR_W-1:0] block_base(input logic [BLK_W-1:0] b);
    return {b, {BLK_SHIFT{1'b0}}};
  endfunction

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata;

  logic sts_wr;
  assign sts_wr = reg_wr && (reg_addr == OFS_STATUS);
  assign cmd_wr = reg_wr && (reg_addr == OFS_CMD);

  for (genvar i = 0; i < N_SRC; i++) begin : g_dec
    assign sts_clr[i] = sts_wr & reg_wdata[sts_pos(i)];
    assign cmd_wen[i] = reg_wdata[en_pos(i)];
  end

  always_comb begin
    case (reg_addr)
      OFS_STATUS: reg_rdata = DATA_W'(status_word(flag));
      OFS_CMD:    reg_rdata = DATA_W'(cmd_word(en));
      OFS_ADDR:   reg_rdata = DATA_W'(block_base(cap_blk));
      OFS_SYN:    reg_rdata = DATA_W'(cap_syn);
      OFS_CHAN:   reg_rdata = DATA_W'(cap_chan);
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture import ecc_cap_pkg::*; #(
  parameter int ADDR_W    = 32,
  parameter int BLK_SHIFT = 12,
  parameter int SYN_W     = 8,
  parameter int DATA_W    = 32,
  localparam int BLK_W    = ADDR_W - BLK_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_evt,
  input  logic              ue_evt,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic [SYN_W-1:0]  evt_syn,
  input  logic              evt_chan,
  input  logic              reg_wr,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              err_irq
);
  logic [N_SRC-1:0] evt_set, sts_clr, flag, held, en, cmd_wen;
  logic             cmd_wr, take_ue, take_ce;
  logic [BLK_W-1:0] cap_blk;
  logic [SYN_W-1:0] cap_syn;
  logic             cap_chan;

  assign evt_set[SRC_CE] = ce_evt;
  assign evt_set[SRC_UE] = ue_evt;

  ecc_flag_bank #(.NF(N_SRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(evt_set), .clr_i(sts_clr),
    .flag_o(flag), .held_o(held)
  );

  ecc_capture #(.ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT), .SYN_W(SYN_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .ce_evt(ce_evt), .ue_evt(ue_evt),
    .evt_addr(evt_addr), .evt_syn(evt_syn), .evt_chan(evt_chan),
    .ce_held(held[SRC_CE]), .ue_held(held[SRC_UE]),
    .cap_blk(cap_blk), .cap_syn(cap_syn), .cap_chan(cap_chan),
    .take_ue(take_ue), .take_ce(take_ce)
  );

  ecc_cmd_irq #(.NF(N_SRC)) u_cmd (
    .clk(clk), .rst_n(rst_n), .wr_i(cmd_wr), .wen_i(cmd_wen),
    .flag_i(flag), .en_o(en), .irq_o(err_irq)
  );

  ecc_reg_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT), .SYN_W(SYN_W)) u_port (
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .flag(flag), .en(en), .cap_blk(cap_blk), .cap_syn(cap_syn), .cap_chan(cap_chan),
    .sts_clr(sts_clr), .cmd_wr(cmd_wr), .cmd_wen(cmd_wen), .reg_rdata(reg_rdata)
  );

  // R9: two captures never fire together
  assert_one_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_ue && take_ce));
  // R7: an accepted uncorrectable event leaves the uncorrectable flag set
  assert_ue_flagged_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take_ue |=> flag[SRC_UE]);
endmodule

// File: tb/ecc_err_capture_test.sv
`timescale 1ns/1ps
module ecc_err_capture_test;
  import ecc_cap_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_evt = 1'b0, ue_evt = 1'b0, evt_chan = 1'b0;
  logic [31:0] evt_addr = '0;
  logic [7:0]  evt_syn = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        err_irq;

  int nchk = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  ecc_err_capture uut (
    .clk(clk), .rst_n(rst_n), .ce_evt(ce_evt), .ue_evt(ue_evt),
    .evt_addr(evt_addr), .evt_syn(evt_syn), .evt_chan(evt_chan),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .err_irq(err_irq)
  );

  typedef struct packed {
    logic [15:0] clr;
    logic        ce;
    logic        ue;
    logic [31:0] addr;
    logic [7:0]  syn;
    logic        ch;
    logic [15:0] est;
    logic [31:0] eaddr;
    logic [7:0]  esyn;
    logic        ech;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{16'h0000, 1'b1, 1'b0, 32'h1234_5678, 8'h3c, 1'b1, 16'h0001, 32'h1234_5000, 8'h3c, 1'b1},
    '{16'h0000, 1'b1, 1'b0, 32'hAAAA_A111, 8'h55, 1'b0, 16'h0001, 32'h1234_5000, 8'h3c, 1'b1},
    '{16'h0000, 1'b0, 1'b1, 32'h0BAD_CFFF, 8'h99, 1'b0, 16'h0081, 32'h0BAD_C000, 8'h99, 1'b0},
    '{16'h0000, 1'b1, 1'b0, 32'h7777_7777, 8'h11, 1'b1, 16'h0081, 32'h0BAD_C000, 8'h99, 1'b0},
    '{16'h0000, 1'b0, 1'b1, 32'h5555_5555, 8'h22, 1'b1, 16'h0081, 32'h0BAD_C000, 8'h99, 1'b0},
    '{16'h0001, 1'b0, 1'b0, 32'h0,         8'h00, 1'b0, 16'h0080, 32'h0BAD_C000, 8'h99, 1'b0},
    '{16'h0080, 1'b0, 1'b0, 32'h0,         8'h00, 1'b0, 16'h0000, 32'h0BAD_C000, 8'h99, 1'b0},
    '{16'h0000, 1'b1, 1'b0, 32'hFFFF_FFFF, 8'hff, 1'b1, 16'h0001, 32'hFFFF_F000, 8'hff, 1'b1},
    '{16'h0001, 1'b1, 1'b1, 32'h0000_1000, 8'h5a, 1'b0, 16'h0081, 32'h0000_1000, 8'h5a, 1'b0},
    '{16'h0081, 1'b0, 1'b0, 32'h0,         8'h00, 1'b0, 16'h0000, 32'h0000_1000, 8'h5a, 1'b0},
    '{16'h0000, 1'b1, 1'b0, 32'h0000_0FFF, 8'h01, 1'b0, 16'h0001, 32'h0000_0000, 8'h01, 1'b0},
    '{16'hff7e, 1'b0, 1'b0, 32'h0,         8'h00, 1'b0, 16'h0001, 32'h0000_0000, 8'h01, 1'b0}
  };

  function automatic string vtag(input int i);
    case (i)
      0:  return "R2 R4 R5 R6 first correctable";
      1:  return "R6 correctable into occupied bank";
      2:  return "R7 uncorrectable over correctable";
      3:  return "R8 correctable after uncorrectable";
      4:  return "R8 second uncorrectable";
      5:  return "R3 clear bit 0 only";
      6:  return "R3 clear bit 7";
      7:  return "R10 fresh capture after clear";
      8:  return "R9 simultaneous events";
      9:  return "R3 clear both";
      10: return "R4 R10 low bits dropped";
      default: return "R3 zero bits and reserved bits leave status";
    endcase
  endfunction

  task automatic cyc(input logic wr, input logic [2:0] wa, input logic [31:0] wd,
                     input logic ce, input logic ue, input logic [31:0] a,
                     input logic [7:0] s, input logic c);
    @(negedge clk);
    reg_wr = wr; reg_addr = wa; reg_wdata = wd;
    ce_evt = ce; ue_evt = ue; evt_addr = a; evt_syn = s; evt_chan = c;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; ce_evt = 1'b0; ue_evt = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    nchk++;
    if (reg_rdata !== exp) begin
      nfail++;
      $display("FAIL %s: offset %0d got %h expected %h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic irq_chk(input string tag, input logic exp);
    #1;
    nchk++;
    if (err_irq !== exp) begin
      nfail++;
      $display("FAIL %s: err_irq got %b expected %b", tag, err_irq, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd_chk("R1 status", OFS_STATUS, 32'h0);
    rd_chk("R1 cmd", OFS_CMD, 32'h0);
    rd_chk("R1 addr", OFS_ADDR, 32'h0);
    rd_chk("R1 syn", OFS_SYN, 32'h0);
    rd_chk("R1 chan", OFS_CHAN, 32'h0);
    irq_chk("R1 irq", 1'b0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].clr != 16'h0)
        cyc(1'b1, OFS_STATUS, {16'h0, VECS[i].clr}, 1'b0, 1'b0, 32'h0, 8'h0, 1'b0);
      if (VECS[i].ce || VECS[i].ue)
        cyc(1'b0, OFS_STATUS, 32'h0, VECS[i].ce, VECS[i].ue, VECS[i].addr, VECS[i].syn, VECS[i].ch);
      rd_chk(vtag(i), OFS_STATUS, {16'h0, VECS[i].est});
      rd_chk(vtag(i), OFS_ADDR, VECS[i].eaddr);
      rd_chk(vtag(i), OFS_SYN, {24'h0, VECS[i].esyn});
      rd_chk(vtag(i), OFS_CHAN, {31'h0, VECS[i].ech});
    end

    // R3 R10: clear and new correctable event in the same cycle
    cyc(1'b1, OFS_STATUS, 32'h0000_0001, 1'b1, 1'b0, 32'h2468_ACE0, 8'h77, 1'b1);
    rd_chk("R3 set wins over clear", OFS_STATUS, 32'h0000_0001);
    rd_chk("R10 same-cycle clear captures addr", OFS_ADDR, 32'h2468_A000);
    rd_chk("R10 same-cycle clear captures syn", OFS_SYN, 32'h0000_0077);
    rd_chk("R10 same-cycle clear captures chan", OFS_CHAN, 32'h0000_0001);

    // R11 R12: enable correctable signalling
    cyc(1'b1, OFS_CMD, 32'h0000_FFFF, 1'b0, 1'b0, 32'h0, 8'h0, 1'b0);
    rd_chk("R11 cmd keeps only bits 7 and 8", OFS_CMD, 32'h0000_0180);
    @(negedge clk);
    irq_chk("R12 correctable enabled", 1'b1);

    cyc(1'b1, OFS_CMD, 32'h0000_0100, 1'b0, 1'b0, 32'h0, 8'h0, 1'b0);
    rd_chk("R11 cmd uncorrectable only", OFS_CMD, 32'h0000_0100);
    @(negedge clk);
    irq_chk("R12 correctable flag masked", 1'b0);

    cyc(1'b0, OFS_STATUS, 32'h0, 1'b0, 1'b1, 32'h1357_9BDF, 8'hc3, 1'b0);
    rd_chk("R7 both bits", OFS_STATUS, 32'h0000_0081);
    rd_chk("R7 addr replaced", OFS_ADDR, 32'h1357_9000);
    @(negedge clk);
    irq_chk("R12 uncorrectable enabled", 1'b1);

    // R13: writes to read-only and unmapped offsets
    cyc(1'b1, OFS_ADDR, 32'hFFFF_FFFF, 1'b0, 1'b0, 32'h0, 8'h0, 1'b0);
    cyc(1'b1, OFS_SYN, 32'hFFFF_FFFF, 1'b0, 1'b0, 32'h0, 8'h0, 1'b0);
    cyc(1'b1, OFS_CHAN, 32'hFFFF_FFFF, 1'b0, 1'b0, 32'h0, 8'h0, 1'b0);
    cyc(1'b1, 3'd5, 32'hFFFF_FFFF, 1'b0, 1'b0, 32'h0, 8'h0, 1'b0);
    rd_chk("R13 addr unchanged", OFS_ADDR, 32'h1357_9000);
    rd_chk("R13 syn unchanged", OFS_SYN, 32'h0000_00c3);
    rd_chk("R13 chan unchanged", OFS_CHAN, 32'h0);
    rd_chk("R13 status unchanged", OFS_STATUS, 32'h0000_0081);
    rd_chk("R13 cmd unchanged", OFS_CMD, 32'h0000_0100);
    rd_chk("R13 unmapped reads zero", 3'd5, 32'h0);
    rd_chk("R13 unmapped 7 reads zero", 3'd7, 32'h0);

    // R12: clearing the flags drops the signal
    cyc(1'b1, OFS_STATUS, 32'h0000_0081, 1'b0, 1'b0, 32'h0, 8'h0, 1'b0);
    rd_chk("R3 clear all", OFS_STATUS, 32'h0);
    @(negedge clk);
    irq_chk("R12 quiet after clear", 1'b0);

    cyc(1'b1, OFS_CMD, 32'h0, 1'b0, 1'b0, 32'h0, 8'h0, 1'b0);
    rd_chk("R11 cmd cleared", OFS_CMD, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule